// File: doc/BRIEF.md
# Symmetric Shift-Add FIR Filter

This block is a linear-phase FIR filter with fixed coefficients, written in direct form. Each clock it can accept one signed sample, marked by a valid strobe. Each clock it also presents one filtered result with its own valid strobe. The coefficient set is mirror-symmetric. Each pair of taps that shares a weight is therefore summed first, and that sum is multiplied once. Every constant product is built from shifted additions and subtractions. Those come from the canonical signed digit form of the weight, which the code derives at elaboration. No general multiplier is used.

Only the unique half of the coefficient set is given as a parameter. The tap count may be even or odd. With an odd count, the middle tap has no partner and is scaled alone. A register sits between the shift-add products and the final summation. The path from a tap register to the output register is therefore cut in two, and the latency is fixed at three cycles from an accepted sample to its result.

Top module: `sym_csd_fir`

## Requirements
- R1: While rst_ni is low and on the first cycle after its release, valid_o is 0 and y_o is 0.
- R2: For each accepted sample, y_o equals the sum of h[k]·s[n-k] over k = 0..NUM_TAPS-1. Here s[n] is the newest accepted sample and s[n-k] is the k-th earlier accepted sample, with zero before reset. x_i is two's complement.
- R3: valid_o is high exactly three clock cycles after the clock edge at which valid_i was sampled high, and low otherwise.
- R4: A cycle with valid_i low does not shift the sample history. While valid_o is low, y_o keeps the last result it presented, which is 0 after reset.
- R5: With full-scale inputs, y_o is exact with no wraparound. This includes every sample at the most negative code, and samples whose signs follow the signs of the weights.
- R6: A single accepted sample of value 1 followed by zero samples gives the results h[0], h[1], …, h[NUM_TAPS-1] in that order. Here h[k] = h[NUM_TAPS-1-k], and h[k] for k below (NUM_TAPS+1)/2 is field k of COEF_VEC, COEF_W bits wide, with field 0 in the least significant bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| x_i | input | DATA_W | Signed input sample |
| valid_o | output | 1 | Result strobe, valid_i delayed three cycles |
| y_o | output | ACC_W | Signed filter result |

## Verification
A fault in the sample history, for example a missed shift, a shift on an idle cycle or a wrong mirror pairing, changes every later result for as long as the bad sample stays in the window. It shows on y_o three cycles after the sample that caused it, and the impulse run shows it tap by tap. A wrong CSD digit gives an error in proportion to the pair sum, so it appears on the first nonzero sample through that pair. A slip in the strobe pipeline shows at once as a misaligned valid_o, or as a held value that changes.

// File: rtl/sym_fir_pkg.sv
package sym_fir_pkg;

  // CSD recoding: {neg_mask, pos_mask}, 32 digits each
  function automatic logic [63:0] csd_encode(input int value);
    int          x;
    logic [31:0] p;
    logic [31:0] n;
    x = value;
    p = '0;
    n = '0;
    for (int i = 0; i < 32; i++) begin
      if (x[0]) begin
        if ((x & 3) == 1) begin
          p[i] = 1'b1;
          x    = x - 1;
        end else begin
          n[i] = 1'b1;
          x    = x + 1;
        end
      end
      x = x >>> 1;
    end
    return {n, p};
  endfunction

endpackage

// File: rtl/sym_fir_taps.sv
module sym_fir_taps #(
  parameter int NUM_TAPS = 12,
  parameter int DATA_W   = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             valid_i,
  input  logic [DATA_W-1:0]                x_i,
  output logic [NUM_TAPS-1:0][DATA_W-1:0]  taps_o
);

  logic [NUM_TAPS-1:0][DATA_W-1:0] taps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      taps_q <= '0;
    else if (valid_i) taps_q <= {taps_q[NUM_TAPS-2:0], x_i};
  end

  assign taps_o = taps_q;

  AST_TAPS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(taps_q)); // R4

endmodule

// File: rtl/sym_fir_pair.sv
module sym_fir_pair
  import sym_fir_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  parameter int COEF   = 1,
  localparam int PRE_W  = DATA_W + 1,
  localparam int PROD_W = PRE_W + COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [PROD_W-1:0] prod_o
);

  localparam int          CSD_W = COEF_W + 1;
  localparam logic [63:0] ENC   = csd_encode(COEF);
  localparam logic [31:0] POS   = ENC[31:0];
  localparam logic [31:0] NEG   = ENC[63:32];

  logic signed [PRE_W-1:0]  pre_sum;
  logic signed [PROD_W-1:0] pre_ext;
  logic signed [PROD_W-1:0] term [CSD_W];
  logic signed [PROD_W-1:0] prod_d;
  logic signed [PROD_W-1:0] prod_q;

  // mirrored pair shares one multiplier
  assign pre_sum = PRE_W'($signed(a_i)) + PRE_W'($signed(b_i));
  assign pre_ext = PROD_W'(pre_sum);

  for (genvar i = 0; i < CSD_W; i++) begin : g_digit
    if (POS[i]) begin : g_pos
      assign term[i] = pre_ext <<< i;
    end else if (NEG[i]) begin : g_neg
      assign term[i] = -(pre_ext <<< i);
    end else begin : g_zero
      assign term[i] = '0;
    end
  end

  always_comb begin
    prod_d = '0;
    for (int i = 0; i < CSD_W; i++) prod_d = prod_d + term[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prod_q <= '0;
    else         prod_q <= prod_d;
  end

  assign prod_o = prod_q;

  logic signed [PROD_W+1:0] ref_prod;
  assign ref_prod = (PROD_W+2)'(pre_sum) * (PROD_W+2)'(COEF);

  AST_CSD_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((PROD_W+2)'(prod_q) == $past(ref_prod))); // R2

endmodule

// File: rtl/sym_fir_accum.sv
module sym_fir_accum #(
  parameter int NUM_PROD = 6,
  parameter int PROD_W   = 23,
  parameter int ACC_W    = 25
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_PROD-1:0][PROD_W-1:0]  prods_i,
  output logic [ACC_W-1:0]                 y_o
);

  localparam int WIDE_W = ACC_W + 2;

  logic signed [WIDE_W-1:0] wide_sum;
  logic        [ACC_W-1:0]  y_q;

  always_comb begin
    wide_sum = '0;
    for (int k = 0; k < NUM_PROD; k++)
      wide_sum = wide_sum + WIDE_W'($signed(prods_i[k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) y_q <= '0;
    else         y_q <= wide_sum[ACC_W-1:0];
  end

  assign y_o = y_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_sum[WIDE_W-1:ACC_W-1] == '0) || (wide_sum[WIDE_W-1:ACC_W-1] == '1)); // R5

endmodule

// File: rtl/sym_csd_fir.sv
module sym_csd_fir #(
  parameter int NUM_TAPS = 12,
  parameter int DATA_W   = 12,
  parameter int COEF_W   = 10,
  localparam int NUM_UNIQ = (NUM_TAPS + 1) / 2,
  parameter logic [NUM_UNIQ*COEF_W-1:0] COEF_VEC =
    {10'sd127, 10'sd78, 10'sd29, -10'sd17, 10'sd5, -10'sd3},
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(NUM_UNIQ),
  localparam int PROD_W = DATA_W + 1 + COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] x_i,
  output logic              valid_o,
  output logic [ACC_W-1:0]  y_o
);

  localparam int LATENCY = 3;

  logic [NUM_TAPS-1:0][DATA_W-1:0] taps;
  logic [NUM_UNIQ-1:0][PROD_W-1:0] prods;
  logic [LATENCY-1:0]              vld_q;

  sym_fir_taps #(
    .NUM_TAPS (NUM_TAPS),
    .DATA_W   (DATA_W)
  ) u_taps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .x_i     (x_i),
    .taps_o  (taps)
  );

  for (genvar p = 0; p < NUM_UNIQ; p++) begin : g_pair
    localparam logic signed [COEF_W-1:0] CK = COEF_VEC[p*COEF_W +: COEF_W];
    logic [DATA_W-1:0] partner;
    if (p == NUM_TAPS - 1 - p) begin : g_centre
      assign partner = '0;
    end else begin : g_mirror
      assign partner = taps[NUM_TAPS-1-p];
    end
    sym_fir_pair #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .COEF   (int'(CK))
    ) u_pair (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (taps[p]),
      .b_i    (partner),
      .prod_o (prods[p])
    );
  end

  sym_fir_accum #(
    .NUM_PROD (NUM_UNIQ),
    .PROD_W   (PROD_W),
    .ACC_W    (ACC_W)
  ) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .prods_i (prods),
    .y_o     (y_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else         vld_q <= {vld_q[LATENCY-2:0], valid_i};
  end

  assign valid_o = vld_q[LATENCY-1];

  logic [1:0] since_rst_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  since_rst_q <= '0;
    else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd3) |-> (valid_o == $past(valid_i, 3))); // R3

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst_q == 2'd0) |-> (!valid_o && (y_o == '0))); // R1

endmodule

// File: tb/sym_csd_fir_bench.sv
module sym_csd_fir_bench;

  localparam int N     = 12;
  localparam int DW    = 12;
  localparam int ACC_W = 25;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             valid_i;
  logic [DW-1:0]    x_i;
  logic             valid_o;
  logic [ACC_W-1:0] y_o;

  always #2 clk_i = ~clk_i;

  sym_csd_fir u_sym_csd_fir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .x_i     (x_i),
    .valid_o (valid_o),
    .y_o     (y_o)
  );

  int     n_cmp = 0;
  int     n_bad = 0;
  int     hu [6] = '{-3, 5, -17, 29, 78, 127};
  longint hist [N];
  longint expq [$];
  string  tagq [$];
  logic   vq [3];
  longint last_y = 0;
  string  cur_tag = "R2";

  function automatic longint coef(input int k);
    return longint'(hu[(k < 6) ? k : (N - 1 - k)]);
  endfunction

  function automatic longint conv();
    longint s = 0;
    for (int k = 0; k < N; k++) s += coef(k) * hist[k];
    return s;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FIL-%s: %s actual=%0d expected=%0d", "", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input int x);
    longint yv;
    @(negedge clk_i);
    yv = longint'($signed(y_o));
    check("R3", longint'(valid_o), longint'(vq[2]));
    if (valid_o) begin
      if (expq.size() > 0) begin
        check(tagq.pop_front(), yv, expq.pop_front());
      end
      last_y = yv;
    end else begin
      check("R4", yv, last_y);
    end
    vq[2] = vq[1];
    vq[1] = vq[0];
    vq[0] = v;
    valid_i = v;
    x_i = DW'(x);
    if (v) begin
      for (int k = N - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'(x);
      expq.push_back(conv());
      tagq.push_back(cur_tag);
    end
  endtask

  initial begin
    for (int k = 0; k < N; k++) hist[k] = 0;
    for (int k = 0; k < 3; k++) vq[k] = 1'b0;
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    x_i     = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check("R1", longint'(valid_o), 0);
    check("R1", longint'($signed(y_o)), 0);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    check("R1", longint'(valid_o), 0);
    check("R1", longint'($signed(y_o)), 0);
    // R6 impulse
    cur_tag = "R6";
    step(1'b1, 1);
    for (int i = 0; i < N + 2; i++) step(1'b1, 0);
    // R4 gaps with held history
    cur_tag = "R4";
    step(1'b1, 700);
    for (int i = 0; i < 6; i++) step(1'b0, 1500 - i * 400);
    step(1'b1, -900);
    for (int i = 0; i < 4; i++) step(1'b0, -2048);
    // R5 full scale, signs matched to weights
    cur_tag = "R5";
    for (int k = N - 1; k >= 0; k--) step(1'b1, (coef(k) > 0) ? 2047 : -2048);
    for (int k = N - 1; k >= 0; k--) step(1'b1, (coef(k) > 0) ? -2048 : 2047);
    for (int i = 0; i < N + 1; i++) step(1'b1, -2048);
    // R2 random, mixed validity
    cur_tag = "R2";
    for (int i = 0; i < 600; i++) begin
      step(($urandom_range(99) < 70), int'($urandom_range(4095)) - 2048);
    end
    for (int i = 0; i < 6; i++) step(1'b0, 0);
    check("R2", longint'(expq.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R2: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule